// File: doc/BRIEF.md
# Asynchronous External Memory Controller

This block sits between a simple host request port and a parallel asynchronous memory bus. It is meant for static RAM, NOR flash and NAND-style parts. Each host request is one read or one write. The controller runs it as a timed cycle on the memory pins, in three phases: setup, strobe and hold. When the cycle is over it returns a one-clock ready pulse, together with the read data for a read.

The top two address bits pick one of four active-low chip selects. Each select covers a 64 MiB window, so the host reaches 256 MiB in total. Every select has its own settings, applied through per-select configuration ports:

- read and write phase counts,
- a minimum turnaround gap,
- a mode that asserts the chip select only during the strobe,
- an extended-wait mode that lets the memory stretch the strobe,
- an 8- or 16-bit data width.

The configuration of the addressed select is latched when a request is accepted, so changing the configuration while the controller is idle is safe.

Top module: `async_mem_ctrl`

## Requirements
- R1: The host address bits [27:26] select which `mem_cs_n` bit goes low (value k drives bit k low). At most one chip select is low at any time.
- R2: A read asserts the chip select for setup cycles before `mem_oe_n` goes low. `mem_oe_n` then stays low for the strobe count. The chip select then stays high-side of the strobe for the hold count, each count taken from the read settings of the addressed select.
- R3: A write uses the write setup, strobe and hold counts of the addressed select, with `mem_we_n` low during the strobe. The read counts have no effect on a write.
- R4: Any setup, strobe or hold count programmed as 0 produces a phase of exactly one clock.
- R5: After an access, the next access starts no sooner than max(1, T) idle clocks later, where T is the turnaround count of the previous access's select. When the next access has the same direction and the same select as the previous one, exactly one idle clock separates them.
- R6: With select-strobe mode on, the chip select is low only during strobe clocks. With it off, the chip select is low from the first setup clock through the last hold clock.
- R7: With extended wait on, the strobe ends on the first clock after the count has expired in which the two-flop-synchronized `mem_wait` is low. A wait input released during strobe clock W therefore gives a strobe of max(S, W+2) clocks. With extended wait off, `mem_wait` has no effect.
- R8: In 8-bit mode, `mem_addr` equals host address bits [25:0]. Writes drive the low byte lane with the upper lane at zero, and `rsp_rdata[15:8]` reads as zero.
- R9: In 16-bit mode, `mem_addr` equals host address bits [25:1], and writes and reads use all 16 data bits.
- R10: Read data is sampled from `mem_dq_in` on the final strobe clock and shown on `rsp_rdata` when `req_ready` is high. `req_ready` is high for exactly one clock: the last hold clock.
- R11: `mem_dq_oe` is high during a write from the first setup clock through the last hold clock, and low during reads and idle.
- R12: During and after reset: all chip selects, `mem_oe_n` and `mem_we_n` are high, while `mem_dq_oe` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_setup | input | 4x4 | Read setup count per select |
| cfg_rd_strobe | input | 4x4 | Read strobe count per select |
| cfg_rd_hold | input | 4x4 | Read hold count per select |
| cfg_wr_setup | input | 4x4 | Write setup count per select |
| cfg_wr_strobe | input | 4x4 | Write strobe count per select |
| cfg_wr_hold | input | 4x4 | Write hold count per select |
| cfg_turn | input | 4x4 | Turnaround gap per select |
| cfg_sel_strobe | input | 4 | Select-strobe mode per select |
| cfg_ext_wait | input | 4 | Extended-wait enable per select |
| cfg_wide | input | 4 | 1 = 16-bit bus, 0 = 8-bit bus |
| req_valid | input | 1 | Host request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Host byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | 26 | Memory address |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable (low = tri-state) |
| mem_dq_in | input | 16 | Data from memory |
| mem_wait | input | 1 | Active-high strobe-extend request |

## Verification
Two events can land on the same clock: the programmed strobe count running out, and the synchronized wait falling. The bench provokes this by releasing `mem_wait` in a chosen strobe clock. It measures the strobe length against max(S, W+2), using release points both before and after the count expiry.

The bench also checks how the turnaround gap interacts with the ready pulse. It queues the next request on the same clock that `req_ready` is seen. It then counts the idle clocks for like and unlike access pairs against the value each pair should produce.

// File: rtl/amc_pkg.sv
package amc_pkg;
    parameter int unsigned AMC_CW = 4;

    typedef logic [AMC_CW-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        cnt_t rd_setup;
        cnt_t rd_strobe;
        cnt_t rd_hold;
        cnt_t wr_setup;
        cnt_t wr_strobe;
        cnt_t wr_hold;
        cnt_t turn;
        logic sel_strobe;
        logic ext_wait;
        logic wide;
    } cs_cfg_t;

    function automatic cnt_t eff_cnt(cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    function automatic cnt_t load_cnt(cnt_t v);
        return eff_cnt(v) - cnt_t'(1);
    endfunction
endpackage

// File: rtl/amc_wait_sync.sv
module amc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[STAGES-2:0], din};
    end

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/amc_cfg_mux.sv
module amc_cfg_mux import amc_pkg::*; #(
    parameter  int NCS  = 4,
    localparam int SELW = $clog2(NCS)
) (
    input  logic [NCS-1:0][AMC_CW-1:0] rd_setup,
    input  logic [NCS-1:0][AMC_CW-1:0] rd_strobe,
    input  logic [NCS-1:0][AMC_CW-1:0] rd_hold,
    input  logic [NCS-1:0][AMC_CW-1:0] wr_setup,
    input  logic [NCS-1:0][AMC_CW-1:0] wr_strobe,
    input  logic [NCS-1:0][AMC_CW-1:0] wr_hold,
    input  logic [NCS-1:0][AMC_CW-1:0] turn,
    input  logic [NCS-1:0]             sel_strobe,
    input  logic [NCS-1:0]             ext_wait,
    input  logic [NCS-1:0]             wide,
    input  logic [SELW-1:0]            sel,
    output cs_cfg_t                    cfg
);
    cs_cfg_t tab [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_tab
        assign tab[g].rd_setup   = rd_setup[g];
        assign tab[g].rd_strobe  = rd_strobe[g];
        assign tab[g].rd_hold    = rd_hold[g];
        assign tab[g].wr_setup   = wr_setup[g];
        assign tab[g].wr_strobe  = wr_strobe[g];
        assign tab[g].wr_hold    = wr_hold[g];
        assign tab[g].turn       = turn[g];
        assign tab[g].sel_strobe = sel_strobe[g];
        assign tab[g].ext_wait   = ext_wait[g];
        assign tab[g].wide       = wide[g];
    end

    assign cfg = tab[sel];
endmodule

// File: rtl/amc_seq.sv
module amc_seq import amc_pkg::*; #(
    parameter  int NCS  = 4,
    localparam int SELW = $clog2(NCS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [SELW-1:0] req_cs,
    input  cs_cfg_t         req_cfg,
    input  logic            wait_s,
    output phase_e          phase,
    output logic            cur_write,
    output logic [SELW-1:0] cur_cs,
    output cs_cfg_t         cur_cfg,
    output logic            start,
    output logic            capture,
    output logic            done
);
    cnt_t            cnt;
    cnt_t            gap_left;
    logic            prev_valid;
    logic [SELW-1:0] prev_cs;
    logic            prev_wr;
    logic            like;
    logic            stretch;
    logic            strobe_end;

    assign like       = prev_valid && (prev_cs == req_cs) && (prev_wr == req_write);
    assign start      = (phase == PH_IDLE) && req_valid && (like || (gap_left <= cnt_t'(1)));
    assign stretch    = cur_cfg.ext_wait && wait_s;
    assign strobe_end = (phase == PH_STROBE) && (cnt == '0) && !stretch;
    assign capture    = strobe_end && !cur_write;
    assign done       = (phase == PH_HOLD) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            gap_left   <= '0;
            prev_valid <= 1'b0;
            prev_cs    <= '0;
            prev_wr    <= 1'b0;
            cur_write  <= 1'b0;
            cur_cs     <= '0;
            cur_cfg    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_SETUP;
                        cur_write <= req_write;
                        cur_cs    <= req_cs;
                        cur_cfg   <= req_cfg;
                        cnt       <= load_cnt(req_write ? req_cfg.wr_setup : req_cfg.rd_setup);
                    end else if (gap_left != '0) begin
                        gap_left <= gap_left - cnt_t'(1);
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= load_cnt(cur_write ? cur_cfg.wr_strobe : cur_cfg.rd_strobe);
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - cnt_t'(1);
                    end else if (strobe_end) begin
                        phase <= PH_HOLD;
                        cnt   <= load_cnt(cur_write ? cur_cfg.wr_hold : cur_cfg.rd_hold);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase      <= PH_IDLE;
                        gap_left   <= cur_cfg.turn;
                        prev_valid <= 1'b1;
                        prev_cs    <= cur_cs;
                        prev_wr    <= cur_write;
                    end else begin
                        cnt <= cnt - cnt_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_STROBE) && (cnt == '0) && cur_cfg.ext_wait && wait_s) |=> (phase == PH_STROBE)); // R7
    AST_STROBE_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE) |=> ((phase == PH_STROBE) || (phase == PH_HOLD))); // R2
    AST_IDLE_TO_SETUP: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE) |=> ((phase == PH_IDLE) || (phase == PH_SETUP))); // R5
endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl import amc_pkg::*; #(
    parameter  int NCS   = 4,
    parameter  int WIN_W = 26,
    parameter  int DW    = 16,
    localparam int SELW  = $clog2(NCS),
    localparam int HAW   = WIN_W + SELW,
    localparam int LANE  = DW / 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_rd_setup,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_rd_strobe,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_rd_hold,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_wr_setup,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_wr_strobe,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_wr_hold,
    input  logic [NCS-1:0][AMC_CW-1:0] cfg_turn,
    input  logic [NCS-1:0]             cfg_sel_strobe,
    input  logic [NCS-1:0]             cfg_ext_wait,
    input  logic [NCS-1:0]             cfg_wide,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic [HAW-1:0]            req_addr,
    input  logic [DW-1:0]             req_wdata,
    output logic                      req_ready,
    output logic [DW-1:0]             rsp_rdata,
    output logic [WIN_W-1:0]          mem_addr,
    output logic [NCS-1:0]            mem_cs_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [DW-1:0]             mem_dq_out,
    output logic                      mem_dq_oe,
    input  logic [DW-1:0]             mem_dq_in,
    input  logic                      mem_wait
);
    logic [SELW-1:0]  req_cs;
    cs_cfg_t          req_cfg;
    cs_cfg_t          cur_cfg;
    phase_e           phase;
    logic             cur_write;
    logic [SELW-1:0]  cur_cs;
    logic             start;
    logic             capture;
    logic             done;
    logic             wait_s;
    logic [WIN_W-1:0] addr_q;
    logic [DW-1:0]    wdata_q;
    logic [DW-1:0]    rdata_q;
    logic             active;
    logic             in_strobe;

    assign req_cs = req_addr[HAW-1:WIN_W];

    amc_wait_sync #(.STAGES(2)) i_wait_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (mem_wait),
        .dout (wait_s)
    );

    amc_cfg_mux #(.NCS(NCS)) i_cfg_mux (
        .rd_setup   (cfg_rd_setup),
        .rd_strobe  (cfg_rd_strobe),
        .rd_hold    (cfg_rd_hold),
        .wr_setup   (cfg_wr_setup),
        .wr_strobe  (cfg_wr_strobe),
        .wr_hold    (cfg_wr_hold),
        .turn       (cfg_turn),
        .sel_strobe (cfg_sel_strobe),
        .ext_wait   (cfg_ext_wait),
        .wide       (cfg_wide),
        .sel        (req_cs),
        .cfg        (req_cfg)
    );

    amc_seq #(.NCS(NCS)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_cs    (req_cs),
        .req_cfg   (req_cfg),
        .wait_s    (wait_s),
        .phase     (phase),
        .cur_write (cur_write),
        .cur_cs    (cur_cs),
        .cur_cfg   (cur_cfg),
        .start     (start),
        .capture   (capture),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                addr_q  <= req_addr[WIN_W-1:0];
                wdata_q <= req_wdata;
            end
            if (capture) begin
                rdata_q <= cur_cfg.wide ? mem_dq_in : {{LANE{1'b0}}, mem_dq_in[LANE-1:0]};
            end
        end
    end

    assign active    = (phase != PH_IDLE);
    assign in_strobe = (phase == PH_STROBE);

    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign mem_cs_n[g] = !((cur_cs == SELW'(g)) && (cur_cfg.sel_strobe ? in_strobe : active));
    end

    assign mem_oe_n   = !(in_strobe && !cur_write);
    assign mem_we_n   = !(in_strobe && cur_write);
    assign mem_dq_oe  = active && cur_write;
    assign mem_dq_out = cur_cfg.wide ? wdata_q : {{LANE{1'b0}}, wdata_q[LANE-1:0]};
    assign mem_addr   = cur_cfg.wide ? {1'b0, addr_q[WIN_W-1:1]} : addr_q;
    assign req_ready  = done;
    assign rsp_rdata  = rdata_q;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n)); // R1
    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !(mem_dq_oe && !mem_oe_n)); // R11
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready); // R10
    AST_SELSTROBE_GATE: assert property (@(posedge clk) disable iff (rst)
        (cur_cfg.sel_strobe && (mem_cs_n != '1)) |-> (!mem_oe_n || !mem_we_n)); // R6
endmodule

// File: tb/test_async_mem_ctrl.sv
module test_async_mem_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0][3:0] c_rs, c_rt, c_rh, c_ws, c_wt, c_wh, c_tn;
    logic [3:0] c_sel, c_ext, c_wide;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [27:0] req_addr  = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] rsp_rdata;
    logic [25:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;
    logic        mem_wait = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int r_idle, r_set, r_stb, r_hold, r_dq, r_ncs;
    logic r_badcs, r_done;
    logic [15:0] r_rd, r_wdq;
    logic [25:0] r_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_dq_in = mem_addr[15:0] ^ 16'h5A3C;

    async_mem_ctrl i_async_mem_ctrl (
        .clk(clk), .rst(rst),
        .cfg_rd_setup(c_rs), .cfg_rd_strobe(c_rt), .cfg_rd_hold(c_rh),
        .cfg_wr_setup(c_ws), .cfg_wr_strobe(c_wt), .cfg_wr_hold(c_wh),
        .cfg_turn(c_tn), .cfg_sel_strobe(c_sel), .cfg_ext_wait(c_ext), .cfg_wide(c_wide),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_wait(mem_wait)
    );

    function automatic int eff(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int cs, input int rs, input int rt, input int rh,
                          input int ws, input int wt, input int wh, input int tn,
                          input logic sel, input logic ext, input logic wide);
        c_rs[cs] = 4'(rs); c_rt[cs] = 4'(rt); c_rh[cs] = 4'(rh);
        c_ws[cs] = 4'(ws); c_wt[cs] = 4'(wt); c_wh[cs] = 4'(wh);
        c_tn[cs] = 4'(tn); c_sel[cs] = sel; c_ext[cs] = ext; c_wide[cs] = wide;
    endtask

    // Called at a negedge; returns at the negedge where req_ready was seen.
    task automatic run_acc(input logic wr, input logic [27:0] a, input logic [15:0] wd,
                           input int wrel);
        logic seen, started, cs_low, stb;
        int sel;
        sel = int'(a[27:26]);
        r_idle = 0; r_set = 0; r_stb = 0; r_hold = 0; r_dq = 0; r_ncs = 0;
        r_badcs = 1'b0; r_done = 1'b0; seen = 1'b0; started = 1'b0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            cs_low = (mem_cs_n != 4'hF);
            stb    = !mem_oe_n || !mem_we_n;
            if (cs_low && (mem_cs_n != ~(4'b0001 << sel))) r_badcs = 1'b1;
            if (!(cs_low || stb || mem_dq_oe) && !started) r_idle++;
            if (cs_low || stb || mem_dq_oe) started = 1'b1;
            if (stb) begin
                r_stb++;
                seen = 1'b1;
                if (wrel != 0 && r_stb == wrel) mem_wait = 1'b0;
            end else if (cs_low) begin
                if (!seen) r_set++;
                else       r_hold++;
            end
            if (cs_low) r_ncs++;
            if (mem_dq_oe) r_dq++;
            if (!mem_we_n) r_wdq = mem_dq_out;
            if (req_ready) begin
                r_rd = rsp_rdata; r_addr = mem_addr;
                req_valid = 1'b0; r_done = 1'b1;
                break;
            end
        end
        chk("R10 completion", int'(r_done), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] e;
        for (int c = 0; c < 4; c++) setcfg(c, 1, 1, 1, 1, 1, 1, 0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk("R12 cs_n", int'(mem_cs_n), 15);
        chk("R12 oe_n", int'(mem_oe_n), 1);
        chk("R12 we_n", int'(mem_we_n), 1);
        chk("R12 dq_oe", int'(mem_dq_oe), 0);
        chk("R12 ready", int'(req_ready), 0);
        rst = 1'b0;

        // R2 R4 read sweep on select 0, 8-bit, normal mode
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 4; t++)
                for (int h = 0; h < 4; h++) begin
                    setcfg(0, s, t, h, 2, 2, 2, 0, 1'b0, 1'b0, 1'b0);
                    run_acc(1'b0, 28'(s * 64 + t * 8 + h + 16'h0120), 16'h0, 0);
                    chk(s == 0 ? "R4 rd setup" : "R2 rd setup", r_set, eff(s));
                    chk(t == 0 ? "R4 rd strobe" : "R2 rd strobe", r_stb, eff(t));
                    chk(h == 0 ? "R4 rd hold" : "R2 rd hold", r_hold, eff(h));
                    chk("R11 no drive on read", r_dq, 0);
                    e = r_addr[15:0] ^ 16'h5A3C;
                    chk("R10 R8 read data", int'(r_rd), int'({8'h00, e[7:0]}));
                end

        // R3 R4 write sweep; read counts fixed at 3 must not matter
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 4; t++)
                for (int h = 0; h < 4; h++) begin
                    setcfg(0, 3, 3, 3, s, t, h, 0, 1'b0, 1'b0, 1'b0);
                    run_acc(1'b1, 28'h0000040, 16'(16'hA100 + s * 16 + t * 4 + h), 0);
                    chk(s == 0 ? "R4 wr setup" : "R3 wr setup", r_set, eff(s));
                    chk(t == 0 ? "R4 wr strobe" : "R3 wr strobe", r_stb, eff(t));
                    chk(h == 0 ? "R4 wr hold" : "R3 wr hold", r_hold, eff(h));
                    chk("R11 drive window", r_dq, eff(s) + eff(t) + eff(h));
                    chk("R8 low lane", int'(r_wdq), int'(16'(s * 16 + t * 4 + h)));
                end

        // R1 decode of all four selects
        for (int c = 0; c < 4; c++) setcfg(c, 1, 2, 1, 1, 2, 1, 0, 1'b0, 1'b0, 1'b0);
        for (int c = 0; c < 4; c++) begin
            run_acc(1'b0, {2'(c), 26'h0000333}, 16'h0, 0);
            chk("R1 only addressed select", int'(r_badcs), 0);
            chk("R1 select active", r_ncs, 4);
        end

        // R5 turnaround
        setcfg(1, 1, 1, 1, 1, 1, 1, 5, 1'b0, 1'b0, 1'b0);
        setcfg(2, 1, 1, 1, 1, 1, 1, 0, 1'b0, 1'b0, 1'b0);
        run_acc(1'b0, 28'h4000010, 16'h0, 0);
        run_acc(1'b0, 28'h4000012, 16'h0, 0);
        chk("R5 read after read same select", r_idle, 1);
        run_acc(1'b1, 28'h4000014, 16'h0011, 0);
        chk("R5 write after read", r_idle, 5);
        run_acc(1'b1, 28'h4000016, 16'h0022, 0);
        chk("R5 write after write same select", r_idle, 1);
        run_acc(1'b0, 28'h8000010, 16'h0, 0);
        chk("R5 other select gap", r_idle, 5);
        run_acc(1'b1, 28'h8000012, 16'h0033, 0);
        chk("R5 zero turnaround", r_idle, 1);

        // R6 select-strobe mode
        setcfg(3, 2, 3, 2, 2, 2, 3, 0, 1'b1, 1'b0, 1'b0);
        run_acc(1'b0, 28'hC000100, 16'h0, 0);
        chk("R6 read cs only in strobe", r_set + r_hold, 0);
        chk("R6 read cs low cycles", r_ncs, 3);
        run_acc(1'b1, 28'hC000102, 16'h0044, 0);
        chk("R6 write cs only in strobe", r_set + r_hold, 0);
        chk("R6 write cs low cycles", r_ncs, 2);
        chk("R11 drive spans full write", r_dq, 7);

        // R7 extended wait
        setcfg(2, 1, 2, 1, 1, 2, 1, 0, 1'b0, 1'b1, 1'b0);
        mem_wait = 1'b1;
        run_acc(1'b0, 28'h8000200, 16'h0, 5);
        chk("R7 stretch released late", r_stb, 7);
        mem_wait = 1'b1;
        run_acc(1'b0, 28'h8000202, 16'h0, 1);
        chk("R7 release at count expiry", r_stb, 3);
        mem_wait = 1'b0;
        run_acc(1'b0, 28'h8000204, 16'h0, 0);
        chk("R7 no wait", r_stb, 2);
        setcfg(0, 1, 2, 1, 1, 2, 1, 0, 1'b0, 1'b0, 1'b0);
        mem_wait = 1'b1;
        run_acc(1'b0, 28'h0000206, 16'h0, 0);
        chk("R7 wait ignored when off", r_stb, 2);
        mem_wait = 1'b0;

        // R8 R9 bus width
        setcfg(1, 1, 1, 1, 1, 1, 1, 0, 1'b0, 1'b0, 1'b1);
        run_acc(1'b0, 28'h5001234, 16'h0, 0);
        chk("R9 word address", int'(r_addr), int'(26'h080091A));
        chk("R9 full read", int'(r_rd), int'(16'h091A ^ 16'h5A3C));
        run_acc(1'b1, 28'h5001234, 16'hBEEF, 0);
        chk("R9 full write", int'(r_wdq), int'(16'hBEEF));
        setcfg(1, 1, 1, 1, 1, 1, 1, 0, 1'b0, 1'b0, 1'b0);
        run_acc(1'b1, 28'h5001235, 16'hBEEF, 0);
        chk("R8 byte address", int'(r_addr), int'(26'h1001235));
        chk("R8 byte write", int'(r_wdq), int'(16'h00EF));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule